// File: doc/BRIEF.md
# Double-Buffered Configuration Pattern Loader

This block keeps a configuration word in three places. A serial shift register takes new bits from a host. A backing store stands in for a nonvolatile array. An active register drives the user logic through a parallel output. The host shifts a word in and then issues a commit, which programs the backing store. A separate init command later copies the backing store into the active register.

Because the store and the active register are separate, the next pattern can be shifted in and committed while the current one keeps running. It only takes effect when the host chooses to issue init. Both commit and init take a fixed, parameterised number of cycles. Init models a swap latency in the tens of microseconds. During an operation a busy flag is high. At completion a single-cycle done flag marks the end.

Top module: `cfg_pattern_loader`

## Requirements
- R1: After reset the active pattern and the backing store are all zeros, and active_valid, busy and done are all low.
- R2: Each clock with shift_en high shifts shift_din into bit 0 of the shift register and moves the other bits one place up. After W enabled clocks, the first bit sent sits in bit W-1, so the word loads MSB first. A clock with shift_en low leaves the shift register unchanged.
- R3: A commit accepted from idle latches the shift register at the accept edge. busy is then high for exactly COMMIT_CYCLES cycles, and the latched word is written to the backing store at the final edge.
- R4: An init accepted from idle keeps busy high for exactly INIT_CYCLES cycles. At the final edge it copies the backing store to active_pat. Before that edge, active_pat does not change.
- R5: active_valid goes high at the completion of the first init and stays high until reset.
- R6: A commit_req or init_req seen while busy is high is ignored: it does not extend busy and does not alter the store or the active pattern.
- R7: If commit_req and init_req are both high in an idle cycle, only the commit is performed.
- R8: A commit never changes active_pat. The backing store can be rewritten while the active pattern keeps its value.
- R9: done is high for exactly the one cycle after busy falls, and at no other time.
- R10: Shifting during a commit does not change the word being committed. That word is the one present at the accept edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Enables one serial shift this clock |
| shift_din | input | 1 | Serial data bit |
| commit_req | input | 1 | Program the backing store from the shift register |
| init_req | input | 1 | Copy the backing store into the active register |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| active_valid | output | 1 | At least one init has completed since reset |
| active_pat | output | W | Active pattern driving user logic |

## Verification
A corrupted backing store cannot be seen directly at the ports. It only shows up as a wrong active_pat at the edge that ends the next init, which can be INIT_CYCLES cycles after the fault. The bench therefore follows every commit with a later init before it judges the store. A stuck or miscounted operation counter shows up sooner, as busy or done out of place within one operation length. A wrong active register shows up as a change in active_pat outside an init completion, in the very cycle it happens.

// File: rtl/cfg_pattern_loader.sv
module cfg_pattern_loader #(
  parameter int W             = 16,
  parameter int COMMIT_CYCLES = 12,
  parameter int INIT_CYCLES   = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_din,
  input  logic         commit_req,
  input  logic         init_req,
  output logic         busy,
  output logic         done,
  output logic         active_valid,
  output logic [W-1:0] active_pat
);

  localparam int MAXC = (COMMIT_CYCLES > INIT_CYCLES) ? COMMIT_CYCLES : INIT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_LOAD} op_t;

  op_t           op;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sreg, snap, store, act_q;
  logic          valid_q, done_q;

  wire idle   = (op == OP_IDLE);
  wire finish = !idle && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op      <= OP_IDLE;
      cnt     <= '0;
      sreg    <= '0;
      snap    <= '0;
      store   <= '0;
      act_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (shift_en) sreg <= {sreg[W-2:0], shift_din};
      done_q <= finish;
      if (idle) begin
        if (commit_req) begin
          snap <= sreg;
          op   <= OP_PROG;
          cnt  <= CW'(COMMIT_CYCLES - 1);
        end else if (init_req) begin
          op  <= OP_LOAD;
          cnt <= CW'(INIT_CYCLES - 1);
        end
      end else if (finish) begin
        op <= OP_IDLE;
        if (op == OP_PROG) begin
          store <= snap;
        end else begin
          act_q   <= store;
          valid_q <= 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign busy         = !idle;
  assign done         = done_q;
  assign active_valid = valid_q;
  assign active_pat   = act_q;

endmodule

// File: rtl/cfg_pattern_loader_chk.sv
module cfg_pattern_loader_chk #(
  parameter int W             = 16,
  parameter int COMMIT_CYCLES = 12,
  parameter int INIT_CYCLES   = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         commit_req,
  input logic         init_req,
  input logic         busy,
  input logic         done,
  input logic         active_valid,
  input logic [W-1:0] active_pat
);

  localparam int MAXC = (COMMIT_CYCLES > INIT_CYCLES) ? COMMIT_CYCLES : INIT_CYCLES;

  logic [31:0] blen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + 1;
    else           blen <= '0;
  end

  AST_ACTIVE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_pat != $past(active_pat)) |-> done); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    active_valid |=> active_valid); // R5
  AST_VALID_RISE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_valid) |-> done); // R5
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_req || init_req)); // R3
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (blen < MAXC)); // R6

endmodule

bind cfg_pattern_loader cfg_pattern_loader_chk #(
  .W(W), .COMMIT_CYCLES(COMMIT_CYCLES), .INIT_CYCLES(INIT_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .init_req(init_req),
  .busy(busy), .done(done), .active_valid(active_valid), .active_pat(active_pat)
);

// File: tb/cfg_pattern_loader_tb.sv
module cfg_pattern_loader_tb;
  localparam int W = 16;
  localparam int NC = 12;
  localparam int NI = 40;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic shift_en = 1'b0, shift_din = 1'b0, commit_req = 1'b0, init_req = 1'b0;
  logic busy, done, active_valid;
  logic [W-1:0] active_pat;

  int checks = 0, failures = 0;
  logic [W-1:0] exp_sreg = '0, exp_store = '0, exp_active = '0;
  logic exp_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_pattern_loader #(.W(W), .COMMIT_CYCLES(NC), .INIT_CYCLES(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_din(shift_din),
    .commit_req(commit_req), .init_req(init_req), .busy(busy), .done(done),
    .active_valid(active_valid), .active_pat(active_pat));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] shifted(input logic [W-1:0] s, input logic b);
    return {s[W-2:0], b};
  endfunction

  task automatic shift_word(input logic [W-1:0] p, input bit gaps);
    for (int i = W - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk); shift_en = 1'b0; shift_din = $urandom % 2;
      end
      @(negedge clk); shift_en = 1'b1; shift_din = p[i];
      exp_sreg = shifted(exp_sreg, p[i]);
    end
    @(negedge clk); shift_en = 1'b0;
  endtask

  // kind: 0 commit, 1 init, 2 both together (commit expected, R7)
  task automatic run_op(input int kind, input bit noise);
    int n;
    bit is_commit;
    logic [W-1:0] snap_e;
    is_commit = (kind != 1);
    n = is_commit ? NC : NI;
    @(negedge clk);
    shift_en = 1'b0;
    commit_req = (kind != 1);
    init_req = (kind != 0);
    snap_e = exp_sreg;
    @(negedge clk);
    commit_req = 1'b0; init_req = 1'b0;
    chk(is_commit ? "R3 busy at accept" : "R4 busy at accept", busy, 1);
    for (int j = 1; j < n; j++) begin
      if (noise) begin
        shift_en = $urandom % 2; shift_din = $urandom % 2;
        if (shift_en) exp_sreg = shifted(exp_sreg, shift_din);
        if (j == 1 && n > 2) begin commit_req = 1'b1; init_req = 1'b1; end
      end
      @(negedge clk);
      commit_req = 1'b0; init_req = 1'b0;
      chk("R6 busy held during op", busy, 1);
      chk("R9 no early done", done, 0);
      chk(is_commit ? "R8 active kept during commit" : "R4 active kept before end", active_pat, exp_active);
    end
    shift_en = 1'b0;
    @(negedge clk);
    if (is_commit) exp_store = snap_e;
    else begin exp_active = exp_store; exp_valid = 1'b1; end
    chk(kind == 2 ? "R7 commit wins, length" : (is_commit ? "R3 busy length" : "R4 busy length"), busy, 0);
    chk("R9 done at end", done, 1);
    chk(is_commit ? "R8 active after commit" : "R4 active after init", active_pat, exp_active);
    chk("R5 valid", active_valid, exp_valid);
    @(negedge clk);
    chk("R6 ignored request did not restart", busy, 0);
    chk("R9 done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 active zero", active_pat, 0);
    chk("R1 valid low", active_valid, 0);
    chk("R1 busy low", busy, 0);
    chk("R1 done low", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {busy, done, active_valid}, 0);

    // R1: init of a blank store keeps zeros but sets valid
    run_op(1, 0);
    chk("R1 blank store", active_pat, 0);

    // directed: blank -> P1 in store -> both P1 -> P2 in store -> both P2
    shift_word(16'hA5C3, 1);
    run_op(0, 0);
    chk("R8 active still blank", active_pat, 0);
    run_op(1, 0);
    chk("R2 MSB first load", active_pat, 16'hA5C3);
    shift_word(16'h0F1E, 0);
    run_op(0, 1);
    chk("R8 old pattern still active", active_pat, 16'hA5C3);
    run_op(1, 1);
    chk("R10 committed word unaffected by shifting", active_pat, 16'h0F1E);

    // R7 simultaneous requests
    shift_word(16'h8001, 0);
    run_op(2, 0);
    chk("R7 active unchanged", active_pat, 16'h0F1E);
    run_op(1, 0);
    chk("R7 commit was done", active_pat, 16'h8001);

    // constrained random
    for (int k = 0; k < 30; k++) begin
      int sel;
      sel = $urandom % 4;
      if (sel == 0) shift_word(W'($urandom), 1);
      else if (sel == 1) run_op(0, $urandom % 2);
      else if (sel == 2) run_op(1, $urandom % 2);
      else run_op(2, $urandom % 2);
    end
    run_op(1, 0);
    chk("R4 final store copy", active_pat, exp_store);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule